// File: doc/BRIEF.md
# Address-Pattern Unlock Command Detector

This block sits beside a byte-wide memory and watches its read accesses for a fixed unlock pattern. The pattern is a run of five prefix addresses followed by a sixth, command-selecting address. When the sixth address selects a nonvolatile store or a nonvolatile recall, the block emits a one-cycle request pulse to the controller that carries out the transfer. A reserved test code in the sixth slot is recognised but produces nothing. The block only decodes commands; it never performs them.

Each access arrives as a single-cycle qualified strobe, one per chip-enable falling edge, so that each access moves the matcher by at most one step. The strobe comes with the write-enable level and the address. Any write, or any read to an address outside the pattern, aborts a partly matched sequence. An access to the first prefix address always starts a fresh attempt at once. While the external busy flag is high, the matcher stays idle and ignores accesses.

Top module: `knock_cmd_detect`

## Requirements
- R1: When reset is high, `store_req`, `recall_req` and `seq_active` are low on the next clock edge and stay low until reset is released.
- R2: Reads, in order, of 0x0E38, 0x31C7, 0x03E0, 0x3C1F, 0x303F and then 0x0FC0 raise `store_req` for exactly the one cycle after the clock edge that samples the sixth strobe. After that, `seq_active` is low.
- R3: The same five prefix reads followed by 0x0C63 raise `recall_req` in the same way.
- R4: The five prefix reads followed by 0x339C raise neither request and leave `seq_active` low.
- R5: A strobe with `wr_n` low (a write access) at any step returns the matcher to idle and raises no request. A later prefix continuation does not resume the old sequence.
- R6: A read strobe whose address is neither the expected next code nor 0x0E38 returns the matcher to idle.
- R7: A read of 0x0E38 that does not match the expected step restarts the sequence with one step matched. `seq_active` stays high, and the next five correct addresses complete a command.
- R8: While `busy` is high, the matcher is held at idle, strobes are ignored, and no request is raised.
- R9: Address bit 14 is ignored; only bits 13:0 are compared.
- R10: `seq_active` is high exactly while one to five steps are matched. Without a strobe or busy, the matched step count never changes, whatever the address does.
- R11: `store_req` and `recall_req` are never high together, and neither is high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_stb | input | 1 | One-cycle pulse per memory access |
| wr_n | input | 1 | Write-enable level at the access, high for a read |
| addr | input | 15 | Access address; bit 14 is ignored |
| busy | input | 1 | Nonvolatile operation in progress; holds the matcher idle |
| store_req | output | 1 | One-cycle store command pulse |
| recall_req | output | 1 | One-cycle recall command pulse |
| seq_active | output | 1 | At least one step of the pattern is matched |

## Verification
The hardest state to reach from the ports is the last step, where five prefix codes are already held and the sixth address chooses among store, recall, the reserved test code and a restart on 0x0E38. Reaching that state needs an unbroken run of six correctly ordered read strobes with no write or busy in between. The vector table therefore walks complete prefixes several times, each ending in a different sixth address. Some runs also break in the middle with a write, a stray read, a busy cycle or a re-entry code, and then finish, to show that the count was restarted rather than resumed.

// File: rtl/knock_pkg.sv
package knock_pkg;
  localparam int CMP_W      = 14;
  localparam int ADDR_W     = 15;
  localparam int PREFIX_LEN = 5;

  localparam logic [CMP_W-1:0] PREFIX_CODE [PREFIX_LEN] = '{
    14'h0E38, 14'h31C7, 14'h03E0, 14'h3C1F, 14'h303F
  };
  localparam logic [CMP_W-1:0] STORE_CODE  = 14'h0FC0;
  localparam logic [CMP_W-1:0] RECALL_CODE = 14'h0C63;
  localparam logic [CMP_W-1:0] TEST_CODE   = 14'h339C;

  typedef enum logic [1:0] {
    CMD_NONE   = 2'd0,
    CMD_STORE  = 2'd1,
    CMD_RECALL = 2'd2,
    CMD_TEST   = 2'd3
  } cmd_e;
endpackage

// File: rtl/knock_addr_match.sv
module knock_addr_match
  import knock_pkg::*;
#(
  parameter int W      = CMP_W,
  parameter int NPRE   = PREFIX_LEN,
  parameter int STEP_W = $clog2(NPRE + 1)
) (
  input  logic [W-1:0]      addr_cmp,
  input  logic [STEP_W-1:0] step,
  output logic              step_hit,
  output logic              first_hit,
  output cmd_e              cmd
);
  logic [NPRE-1:0] pre_hit;

  // one comparator per prefix position
  for (genvar i = 0; i < NPRE; i++) begin : g_pre
    assign pre_hit[i] = (addr_cmp == W'(PREFIX_CODE[i]));
  end

  assign first_hit = pre_hit[0];

  always_comb begin
    step_hit = 1'b0;
    for (int i = 0; i < NPRE; i++) begin
      if (step == STEP_W'(i)) step_hit = pre_hit[i];
    end
  end

  always_comb begin
    if (addr_cmp == W'(STORE_CODE))       cmd = CMD_STORE;
    else if (addr_cmp == W'(RECALL_CODE)) cmd = CMD_RECALL;
    else if (addr_cmp == W'(TEST_CODE))   cmd = CMD_TEST;
    else                                  cmd = CMD_NONE;
  end
endmodule

// File: rtl/knock_step_track.sv
module knock_step_track
  import knock_pkg::*;
#(
  parameter int NPRE   = PREFIX_LEN,
  parameter int STEP_W = $clog2(NPRE + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_stb,
  input  logic              wr_n,
  input  logic              busy,
  input  logic              step_hit,
  input  logic              first_hit,
  input  cmd_e              cmd,
  output logic [STEP_W-1:0] step,
  output logic              active,
  output logic              store_p,
  output logic              recall_p
);
  localparam logic [STEP_W-1:0] LAST = STEP_W'(NPRE);
  localparam logic [STEP_W-1:0] ONE  = STEP_W'(1);

  logic [STEP_W-1:0] step_nx;
  logic              store_nx, recall_nx;

  always_comb begin
    step_nx   = step;
    store_nx  = 1'b0;
    recall_nx = 1'b0;
    if (busy) begin
      step_nx = '0;
    end else if (acc_stb) begin
      if (!wr_n) begin
        step_nx = '0;
      end else if (step == LAST) begin
        unique case (cmd)
          CMD_STORE:  begin store_nx  = 1'b1; step_nx = '0; end
          CMD_RECALL: begin recall_nx = 1'b1; step_nx = '0; end
          default:    step_nx = first_hit ? ONE : '0;
        endcase
      end else if (step_hit) begin
        step_nx = step + ONE;
      end else begin
        step_nx = first_hit ? ONE : '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      step     <= '0;
      active   <= 1'b0;
      store_p  <= 1'b0;
      recall_p <= 1'b0;
    end else begin
      step     <= step_nx;
      active   <= (step_nx != '0);
      store_p  <= store_nx;
      recall_p <= recall_nx;
    end
  end
endmodule

// File: rtl/knock_cmd_detect.sv
module knock_cmd_detect
  import knock_pkg::*;
#(
  parameter int AW   = ADDR_W,
  parameter int CW   = CMP_W,
  parameter int NPRE = PREFIX_LEN
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          acc_stb,
  input  logic          wr_n,
  input  logic [AW-1:0] addr,
  input  logic          busy,
  output logic          store_req,
  output logic          recall_req,
  output logic          seq_active
);
  localparam int STEP_W = $clog2(NPRE + 1);

  logic [STEP_W-1:0] step;
  logic              step_hit, first_hit;
  cmd_e              cmd;

  knock_addr_match #(.W(CW), .NPRE(NPRE), .STEP_W(STEP_W)) u_match (
    .addr_cmp  (addr[CW-1:0]),
    .step      (step),
    .step_hit  (step_hit),
    .first_hit (first_hit),
    .cmd       (cmd)
  );

  knock_step_track #(.NPRE(NPRE), .STEP_W(STEP_W)) u_track (
    .clk       (clk),
    .rst       (rst),
    .acc_stb   (acc_stb),
    .wr_n      (wr_n),
    .busy      (busy),
    .step_hit  (step_hit),
    .first_hit (first_hit),
    .cmd       (cmd),
    .step      (step),
    .active    (seq_active),
    .store_p   (store_req),
    .recall_p  (recall_req)
  );
endmodule

// File: rtl/knock_cmd_detect_chk.sv
module knock_cmd_detect_chk (
  input logic clk,
  input logic rst,
  input logic acc_stb,
  input logic wr_n,
  input logic busy,
  input logic store_req,
  input logic recall_req,
  input logic seq_active
);
  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> !store_req && !recall_req && !seq_active); // R1
  AST_WRITE_ABORT: assert property (@(posedge clk) disable iff (rst) acc_stb && !wr_n |=> !seq_active && !store_req && !recall_req); // R5
  AST_BUSY_IDLE: assert property (@(posedge clk) disable iff (rst) busy |=> !seq_active && !store_req && !recall_req); // R8
  AST_HOLD_NO_STB: assert property (@(posedge clk) disable iff (rst) !acc_stb && !busy |=> $stable(seq_active) && !store_req && !recall_req); // R10
  AST_REQ_EXCL: assert property (@(posedge clk) disable iff (rst) !(store_req && recall_req)); // R11
  AST_STORE_ONE: assert property (@(posedge clk) disable iff (rst) store_req |=> !store_req); // R11
  AST_RECALL_ONE: assert property (@(posedge clk) disable iff (rst) recall_req |=> !recall_req); // R11
  AST_STORE_FROM_ACTIVE: assert property (@(posedge clk) disable iff (rst) $rose(store_req) |-> $past(seq_active) && !seq_active); // R2
  AST_RECALL_FROM_ACTIVE: assert property (@(posedge clk) disable iff (rst) $rose(recall_req) |-> $past(seq_active) && !seq_active); // R3
endmodule

bind knock_cmd_detect knock_cmd_detect_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .acc_stb    (acc_stb),
  .wr_n       (wr_n),
  .busy       (busy),
  .store_req  (store_req),
  .recall_req (recall_req),
  .seq_active (seq_active)
);

// File: tb/knock_cmd_detect_tb.sv
module knock_cmd_detect_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_stb = 1'b0;
  logic        wr_n = 1'b1;
  logic [14:0] addr = '0;
  logic        busy = 1'b0;
  logic        store_req, recall_req, seq_active;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  knock_cmd_detect u_dut (
    .clk(clk), .rst(rst), .acc_stb(acc_stb), .wr_n(wr_n), .addr(addr),
    .busy(busy), .store_req(store_req), .recall_req(recall_req),
    .seq_active(seq_active)
  );

  // entry: {req[3:0], wr_n, busy, addr[14:0], expected {store, recall, active}}
  localparam int NV = 48;
  localparam logic [23:0] VEC [NV] = '{
    // R2: full store pattern
    {4'd2, 1'b1, 1'b0, 15'h0E38, 3'b001}, {4'd2, 1'b1, 1'b0, 15'h31C7, 3'b001},
    {4'd2, 1'b1, 1'b0, 15'h03E0, 3'b001}, {4'd2, 1'b1, 1'b0, 15'h3C1F, 3'b001},
    {4'd2, 1'b1, 1'b0, 15'h303F, 3'b001}, {4'd2, 1'b1, 1'b0, 15'h0FC0, 3'b100},
    // R3 and R9: recall pattern, bit 14 set on the first address
    {4'd9, 1'b1, 1'b0, 15'h4E38, 3'b001}, {4'd3, 1'b1, 1'b0, 15'h31C7, 3'b001},
    {4'd3, 1'b1, 1'b0, 15'h03E0, 3'b001}, {4'd3, 1'b1, 1'b0, 15'h3C1F, 3'b001},
    {4'd3, 1'b1, 1'b0, 15'h303F, 3'b001}, {4'd3, 1'b1, 1'b0, 15'h0C63, 3'b010},
    // R4: reserved test code
    {4'd4, 1'b1, 1'b0, 15'h0E38, 3'b001}, {4'd4, 1'b1, 1'b0, 15'h31C7, 3'b001},
    {4'd4, 1'b1, 1'b0, 15'h03E0, 3'b001}, {4'd4, 1'b1, 1'b0, 15'h3C1F, 3'b001},
    {4'd4, 1'b1, 1'b0, 15'h303F, 3'b001}, {4'd4, 1'b1, 1'b0, 15'h339C, 3'b000},
    // R5: write aborts, continuation does not resume
    {4'd5, 1'b1, 1'b0, 15'h0E38, 3'b001}, {4'd5, 1'b1, 1'b0, 15'h31C7, 3'b001},
    {4'd5, 1'b0, 1'b0, 15'h03E0, 3'b000}, {4'd5, 1'b1, 1'b0, 15'h3C1F, 3'b000},
    // R6: stray read aborts
    {4'd6, 1'b1, 1'b0, 15'h0E38, 3'b001}, {4'd6, 1'b1, 1'b0, 15'h31C7, 3'b001},
    {4'd6, 1'b1, 1'b0, 15'h1234, 3'b000}, {4'd6, 1'b1, 1'b0, 15'h03E0, 3'b000},
    // R7: re-entry on first code mid-sequence
    {4'd7, 1'b1, 1'b0, 15'h0E38, 3'b001}, {4'd7, 1'b1, 1'b0, 15'h31C7, 3'b001},
    {4'd7, 1'b1, 1'b0, 15'h0E38, 3'b001}, {4'd7, 1'b1, 1'b0, 15'h31C7, 3'b001},
    {4'd7, 1'b1, 1'b0, 15'h03E0, 3'b001}, {4'd7, 1'b1, 1'b0, 15'h3C1F, 3'b001},
    {4'd7, 1'b1, 1'b0, 15'h303F, 3'b001}, {4'd7, 1'b1, 1'b0, 15'h0FC0, 3'b100},
    // R8: busy ignores the access and clears the state
    {4'd8, 1'b1, 1'b0, 15'h0E38, 3'b001}, {4'd8, 1'b1, 1'b1, 15'h31C7, 3'b000},
    {4'd8, 1'b1, 1'b0, 15'h31C7, 3'b000},
    // R7: re-entry at the command step, then recall
    {4'd7, 1'b1, 1'b0, 15'h0E38, 3'b001}, {4'd7, 1'b1, 1'b0, 15'h31C7, 3'b001},
    {4'd7, 1'b1, 1'b0, 15'h03E0, 3'b001}, {4'd7, 1'b1, 1'b0, 15'h3C1F, 3'b001},
    {4'd7, 1'b1, 1'b0, 15'h303F, 3'b001}, {4'd7, 1'b1, 1'b0, 15'h0E38, 3'b001},
    {4'd7, 1'b1, 1'b0, 15'h31C7, 3'b001}, {4'd7, 1'b1, 1'b0, 15'h03E0, 3'b001},
    {4'd7, 1'b1, 1'b0, 15'h3C1F, 3'b001}, {4'd7, 1'b1, 1'b0, 15'h303F, 3'b001},
    {4'd7, 1'b1, 1'b0, 15'h0C63, 3'b010}
  };

  function automatic logic [2:0] outs();
    return {store_req, recall_req, seq_active};
  endfunction

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {store,recall,active} actual=%b expected=%b", req, act, exp);
    end
  endtask

  // starts and ends at a falling edge
  task automatic access(input logic w, input logic b, input logic [14:0] a);
    acc_stb = 1'b1; wr_n = w; busy = b; addr = a;
    @(negedge clk);
    acc_stb = 1'b0; busy = 1'b0; wr_n = 1'b1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic prefix();
    access(1'b1, 1'b0, 15'h0E38); access(1'b1, 1'b0, 15'h31C7);
    access(1'b1, 1'b0, 15'h03E0); access(1'b1, 1'b0, 15'h3C1F);
    access(1'b1, 1'b0, 15'h303F);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", outs(), 3'b000);              // R1: reset state
    rst = 1'b0;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      access(VEC[v][19], VEC[v][18], VEC[v][17:3]);
      check($sformatf("R%0d vec%0d", VEC[v][23:20], v), outs(), VEC[v][2:0]);
    end

    // R11: a store pulse lasts one cycle only
    prefix();
    access(1'b1, 1'b0, 15'h0FC0);
    check("R11 store pulse", outs(), 3'b100);
    idle(1);
    check("R11 store drop", outs(), 3'b000);

    // R10: no strobe, changing address, state held
    access(1'b1, 1'b0, 15'h0E38);
    access(1'b1, 1'b0, 15'h31C7);
    addr = 15'h03E0; idle(1);
    addr = 15'h1111; idle(3);
    check("R10 hold", outs(), 3'b001);
    access(1'b1, 1'b0, 15'h03E0); access(1'b1, 1'b0, 15'h3C1F);
    access(1'b1, 1'b0, 15'h303F); access(1'b1, 1'b0, 15'h0C63);
    check("R10 resume to recall", outs(), 3'b010);
    idle(1);
    check("R11 recall drop", outs(), 3'b000);

    // R8: busy without strobe clears a partial sequence
    prefix();
    busy = 1'b1; idle(1); busy = 1'b0;
    check("R8 busy clear", outs(), 3'b000);
    access(1'b1, 1'b0, 15'h0FC0);
    check("R8 no stale store", outs(), 3'b000);

    // R5: write of the command code at the last step
    prefix();
    access(1'b0, 1'b0, 15'h0FC0);
    check("R5 write at last", outs(), 3'b000);

    // R1: reset mid-sequence
    prefix();
    rst = 1'b1; idle(1);
    check("R1 reset clears", outs(), 3'b000);
    rst = 1'b0; idle(1);
    access(1'b1, 1'b0, 15'h0FC0);
    check("R1 no stale after reset", outs(), 3'b000);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule